// File: doc/BRIEF.md
# DMA Channel Control Front End

This block is the register side of a multi-channel DMA controller. Each channel has three 32-bit registers: a memory address, a block control word and a channel control word. One shared enable register holds a gate bit for every channel. When software writes a channel control word with the start bit set, the block checks that channel's gate bit in the enable register. If the gate bit is set, the block sends a single-cycle start request to the transfer engine. The request carries the channel number, the channel's address and block registers, and the control word just written.

The register window is addressed in bytes. Channel n owns a 16-byte slot at offset 0x10*n. Within the slot, the address register is at +0x0, the block register at +0x4, and the control register at both +0x8 and +0xC. The enable register is at 0x70. A sticky restart-status register is at 0x74. The bus carries halfword addresses, so byte-address bit 0 is not present. A halfword access sets `bus_half`, and `bus_addr[1]` picks the upper or lower half.

The engine reports the end of a transfer on a per-channel done line, and that clears the channel's start/busy bit. Writing a start to a channel that is still busy is unusual, so it is recorded in the restart-status register.

Top module: `dmafe_ctrl_front`

## Requirements
- R1: After reset, every address, block, control, enable and restart-status register reads zero, and `start_valid` is low.
- R2: A word write to +0x0 or +0x4 of a channel slot stores the full value, and a read of the same offset returns it.
- R3: A halfword write to the address register, the block register or the enable register replaces only the addressed half with `bus_wdata[15:0]`. `bus_addr[1]`=1 selects bits 31:16; otherwise bits 15:0 are replaced. The other half keeps its value.
- R4: A write of either size to +0x8 or +0xC stores all 32 bits of `bus_wdata` into the control register. Both offsets read back the control register.
- R5: A control write with bit 24 set, to a channel whose enable bit 4n+3 is set, raises `start_valid` for exactly the next cycle. In that cycle `start_chan`=n, `start_addr` and `start_block` hold the channel's registers, and `start_ctrl` holds the written word.
- R6: A control write with bit 24 clear, or to a channel whose enable bit 4n+3 is clear, produces no start. The value is still stored.
- R7: Only channels 0, 1, 2, 3, 4 and 6 can start. A start-bit write to channel 5 never produces a start, even when its enable bit 23 is set.
- R8: A start-bit write to a start-capable channel whose stored bit 24 is already set sets bit n of the status register at 0x74. The bit stays set until a write with a 1 in bit n clears it.
- R9: A pulse on `xfer_done[n]` clears bit 24 of channel n's control register. If a control write to that channel happens in the same cycle, the write wins, and restart detection uses the value stored before the clear.
- R10: Control writes in consecutive cycles to two started channels give starts in consecutive cycles, each with its own channel's payload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 6 | Byte address bits 6:1 within the window |
| bus_half | input | 1 | 1 = halfword access, 0 = word access |
| bus_wdata | input | 32 | Write data; halfword data in bits 15:0 |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| xfer_done | input | 7 | Per-channel transfer completion pulse |
| start_valid | output | 1 | One-cycle start request |
| start_chan | output | 3 | Channel being started |
| start_addr | output | 32 | Channel address register at the start |
| start_block | output | 32 | Channel block register at the start |
| start_ctrl | output | 32 | Control word that caused the start |

## Verification
The hardest case to reach from the ports is the collision between a done pulse and a fresh start write on the same channel in the same cycle. The write has to win, yet a restart must still be recorded against the stale busy bit. The stimulus gets there in two steps. It first starts a channel so that its busy bit is set. It then drives `xfer_done` and a control write on the same negedge, and reads back both the control register and the status register. Back-to-back starts on two channels and channel 5's blocked start are covered by a queue of expected start requests. A monitor flags any start that was not predicted.

// File: rtl/dmafe_pkg.sv
package dmafe_pkg;
  localparam int WORD_W   = 32;
  localparam int BUSY_BIT = 24;

  // byte lanes touched by a write: whole word, or the half chosen by hi
  function automatic logic [WORD_W-1:0] lane_mask(input logic half, input logic hi);
    if (!half)   return '1;
    else if (hi) return {{(WORD_W/2){1'b1}}, {(WORD_W/2){1'b0}}};
    else         return {{(WORD_W/2){1'b0}}, {(WORD_W/2){1'b1}}};
  endfunction

  // halfword data is mirrored onto both halves so the mask can pick either
  function automatic logic [WORD_W-1:0] lane_data(input logic half, input logic [WORD_W-1:0] d);
    return half ? {d[WORD_W/2-1:0], d[WORD_W/2-1:0]} : d;
  endfunction
endpackage

// File: rtl/dmafe_decode.sv
module dmafe_decode #(
  parameter int NUM_CH = 7,
  parameter int ADDR_W = 7
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:1] bus_addr,
  output logic [NUM_CH-1:0] addr_we,
  output logic [NUM_CH-1:0] blk_we,
  output logic [NUM_CH-1:0] ctrl_we,
  output logic              en_we,
  output logic              stat_we
);
  localparam int SLOT_W = ADDR_W - 4;

  logic [SLOT_W-1:0] slot;
  logic [1:0]        fld;

  assign slot = bus_addr[ADDR_W-1:4];
  assign fld  = bus_addr[3:2];

  always_comb begin
    for (int n = 0; n < NUM_CH; n++) begin
      addr_we[n] = bus_wr && (slot == SLOT_W'(n)) && (fld == 2'd0);
      blk_we[n]  = bus_wr && (slot == SLOT_W'(n)) && (fld == 2'd1);
      ctrl_we[n] = bus_wr && (slot == SLOT_W'(n)) && fld[1];
    end
    en_we   = bus_wr && (slot == SLOT_W'(NUM_CH)) && (fld == 2'd0);
    stat_we = bus_wr && (slot == SLOT_W'(NUM_CH)) && (fld == 2'd1);
  end
endmodule

// File: rtl/dmafe_chan_regs.sv
module dmafe_chan_regs
  import dmafe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_we,
  input  logic              blk_we,
  input  logic              ctrl_we,
  input  logic [WORD_W-1:0] wmask,
  input  logic [WORD_W-1:0] wlane,
  input  logic [WORD_W-1:0] wdata,
  input  logic              done,
  output logic [WORD_W-1:0] addr_q,
  output logic [WORD_W-1:0] blk_q,
  output logic [WORD_W-1:0] ctrl_q
);
  logic [WORD_W-1:0] addr_d, blk_d, ctrl_d;
  logic              ctrl_en;

  always_comb begin
    addr_d = (addr_q & ~wmask) | (wlane & wmask);
    blk_d  = (blk_q  & ~wmask) | (wlane & wmask);
    ctrl_d = ctrl_q;
    if (done)    ctrl_d[BUSY_BIT] = 1'b0;
    if (ctrl_we) ctrl_d = wdata;          // write wins over completion
    ctrl_en = ctrl_we || done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      blk_q  <= '0;
      ctrl_q <= '0;
    end else begin
      if (addr_we) addr_q <= addr_d;
      if (blk_we)  blk_q  <= blk_d;
      if (ctrl_en) ctrl_q <= ctrl_d;
    end
  end

  assert_done_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ctrl_we) |=> !ctrl_q[BUSY_BIT]);

  assert_ctrl_full_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> (ctrl_q == $past(wdata)));
endmodule

// File: rtl/dmafe_start_gate.sv
module dmafe_start_gate
  import dmafe_pkg::*;
#(
  parameter int                NUM_CH     = 7,
  parameter logic [NUM_CH-1:0] START_MASK = 7'b1011111,
  localparam int               CH_W       = $clog2(NUM_CH),
  localparam int               MASK_W     = 1 << CH_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_CH-1:0]              ctrl_we,
  input  logic [WORD_W-1:0]              wdata,
  input  logic [NUM_CH-1:0]              gate_en,
  input  logic [NUM_CH-1:0]              busy,
  input  logic [NUM_CH-1:0][WORD_W-1:0]  addr_vec,
  input  logic [NUM_CH-1:0][WORD_W-1:0]  blk_vec,
  input  logic                           stat_we,
  input  logic [NUM_CH-1:0]              stat_clr,
  output logic                           start_valid,
  output logic [CH_W-1:0]                start_chan,
  output logic [WORD_W-1:0]              start_addr,
  output logic [WORD_W-1:0]              start_block,
  output logic [WORD_W-1:0]              start_ctrl,
  output logic [NUM_CH-1:0]              restart_q
);
  localparam logic [MASK_W-1:0] MASK_EXT = MASK_W'(START_MASK);

  logic [NUM_CH-1:0] hits, rehit;
  logic [CH_W-1:0]   sel_chan;
  logic [WORD_W-1:0] sel_addr, sel_blk;
  logic [NUM_CH-1:0] restart_d;
  logic              go;

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_qual
      if (START_MASK[g]) begin : g_cap
        assign hits[g]  = ctrl_we[g] && wdata[BUSY_BIT] && gate_en[g];
        assign rehit[g] = ctrl_we[g] && wdata[BUSY_BIT] && busy[g];
      end else begin : g_nocap
        assign hits[g]  = 1'b0;
        assign rehit[g] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    go       = |hits;
    sel_chan = '0;
    sel_addr = '0;
    sel_blk  = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      if (hits[n]) begin
        sel_chan = CH_W'(n);
        sel_addr = addr_vec[n];
        sel_blk  = blk_vec[n];
      end
    end
    restart_d = (restart_q & ~(stat_we ? stat_clr : '0)) | rehit;  // set wins
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_valid <= 1'b0;
      start_chan  <= '0;
      start_addr  <= '0;
      start_block <= '0;
      start_ctrl  <= '0;
      restart_q   <= '0;
    end else begin
      start_valid <= go;
      restart_q   <= restart_d;
      if (go) begin
        start_chan  <= sel_chan;
        start_addr  <= sel_addr;
        start_block <= sel_blk;
        start_ctrl  <= wdata;
      end
    end
  end

  assert_one_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hits));

  assert_capable_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid |-> MASK_EXT[start_chan]);

  assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_we |=> ((restart_q & $past(restart_q)) == $past(restart_q)));
endmodule

// File: rtl/dmafe_ctrl_front.sv
module dmafe_ctrl_front
  import dmafe_pkg::*;
#(
  parameter int                NUM_CH     = 7,
  parameter int                ADDR_W     = 7,
  parameter logic [NUM_CH-1:0] START_MASK = 7'b1011111,
  localparam int               CH_W       = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:1] bus_addr,
  input  logic              bus_half,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NUM_CH-1:0] xfer_done,
  output logic              start_valid,
  output logic [CH_W-1:0]   start_chan,
  output logic [31:0]       start_addr,
  output logic [31:0]       start_block,
  output logic [31:0]       start_ctrl
);
  localparam int SLOT_W = ADDR_W - 4;

  logic [1:0]                     rst_pipe;
  logic                           rst_s_n;
  logic [WORD_W-1:0]              wmask, wlane;
  logic [NUM_CH-1:0]              addr_we, blk_we, ctrl_we;
  logic                           en_we, stat_we;
  logic [NUM_CH-1:0][WORD_W-1:0]  addr_vec, blk_vec, ctrl_vec;
  logic [NUM_CH-1:0]              busy, gate_en, restart_q;
  logic [WORD_W-1:0]              en_q, en_d;
  logic [SLOT_W-1:0]              rd_slot;
  logic [1:0]                     rd_fld;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  assign wmask = lane_mask(bus_half, bus_addr[1]);
  assign wlane = lane_data(bus_half, bus_wdata);

  dmafe_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .bus_wr(bus_wr), .bus_addr(bus_addr),
    .addr_we(addr_we), .blk_we(blk_we), .ctrl_we(ctrl_we),
    .en_we(en_we), .stat_we(stat_we)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_ch
      dmafe_chan_regs u_regs (
        .clk(clk), .rst_n(rst_s_n),
        .addr_we(addr_we[g]), .blk_we(blk_we[g]), .ctrl_we(ctrl_we[g]),
        .wmask(wmask), .wlane(wlane), .wdata(bus_wdata),
        .done(xfer_done[g]),
        .addr_q(addr_vec[g]), .blk_q(blk_vec[g]), .ctrl_q(ctrl_vec[g])
      );
      assign busy[g]    = ctrl_vec[g][BUSY_BIT];
      assign gate_en[g] = en_q[4*g+3];
    end
  endgenerate

  // shared enable register
  assign en_d = (en_q & ~wmask) | (wlane & wmask);
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)   en_q <= '0;
    else if (en_we) en_q <= en_d;
  end

  dmafe_start_gate #(.NUM_CH(NUM_CH), .START_MASK(START_MASK)) u_gate (
    .clk(clk), .rst_n(rst_s_n),
    .ctrl_we(ctrl_we), .wdata(bus_wdata), .gate_en(gate_en), .busy(busy),
    .addr_vec(addr_vec), .blk_vec(blk_vec),
    .stat_we(stat_we), .stat_clr(NUM_CH'(wlane & wmask)),
    .start_valid(start_valid), .start_chan(start_chan),
    .start_addr(start_addr), .start_block(start_block), .start_ctrl(start_ctrl),
    .restart_q(restart_q)
  );

  // read mux
  assign rd_slot = bus_addr[ADDR_W-1:4];
  assign rd_fld  = bus_addr[3:2];
  always_comb begin
    bus_rdata = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      if (rd_slot == SLOT_W'(n)) begin
        case (rd_fld)
          2'd0:    bus_rdata = addr_vec[n];
          2'd1:    bus_rdata = blk_vec[n];
          default: bus_rdata = ctrl_vec[n];
        endcase
      end
    end
    if (rd_slot == SLOT_W'(NUM_CH)) begin
      if (rd_fld == 2'd0)      bus_rdata = en_q;
      else if (rd_fld == 2'd1) bus_rdata = WORD_W'(restart_q);
    end
  end

  assert_start_cause_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    start_valid |-> $past(bus_wr && bus_wdata[BUSY_BIT]));
endmodule

// File: tb/dmafe_ctrl_front_test.sv
module dmafe_ctrl_front_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] SMASK = 7'b1011111;

  logic        clk, rst_n, bus_wr, bus_half;
  logic [6:1]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, start_addr, start_block, start_ctrl;
  logic [6:0]  xfer_done;
  logic        start_valid;
  logic [2:0]  start_chan;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [31:0] m_addr [7];
  logic [31:0] m_blk  [7];
  logic [31:0] m_ctrl [7];
  logic [31:0] m_en;
  logic [6:0]  m_stat;
  logic [98:0] exp_q [$];

  dmafe_ctrl_front uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_half(bus_half), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .xfer_done(xfer_done), .start_valid(start_valid), .start_chan(start_chan),
    .start_addr(start_addr), .start_block(start_block), .start_ctrl(start_ctrl)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [98:0] got, input logic [98:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // driver: called just after a negedge; models the write and predicts starts
  task automatic wr(input logic [6:0] a, input logic half, input logic [31:0] d);
    logic [2:0]  s;
    logic [1:0]  f;
    logic [31:0] m, l;
    s = a[6:4];
    f = a[3:2];
    m = half ? (a[1] ? 32'hFFFF0000 : 32'h0000FFFF) : 32'hFFFFFFFF;
    l = half ? {d[15:0], d[15:0]} : d;
    bus_wr = 1'b1; bus_addr = a[6:1]; bus_half = half; bus_wdata = d;
    if (s < 3'd7) begin
      if (f == 2'd0)      m_addr[s] = (m_addr[s] & ~m) | (l & m);
      else if (f == 2'd1) m_blk[s]  = (m_blk[s]  & ~m) | (l & m);
      else begin
        if (SMASK[s] && d[24] && m_ctrl[s][24]) m_stat[s] = 1'b1;
        if (SMASK[s] && d[24] && m_en[4*s+3])
          exp_q.push_back({s, m_addr[s], m_blk[s], d});
        m_ctrl[s] = d;
      end
    end else begin
      if (f == 2'd0)      m_en   = (m_en & ~m) | (l & m);
      else if (f == 2'd1) m_stat = m_stat & ~l[6:0] & ~m[6:0] | m_stat & ~l[6:0] & m[6:0] | m_stat & ~m[6:0];
    end
    @(negedge clk);
    bus_wr = 1'b0; bus_half = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, input logic [31:0] exp, input string req);
    bus_addr = a[6:1];
    #1;
    chk(req, 99'(bus_rdata), 99'(exp));
    @(negedge clk);
  endtask

  task automatic done_pulse(input int c);
    xfer_done[c] = 1'b1;
    m_ctrl[c][24] = 1'b0;
    @(negedge clk);
    xfer_done = '0;
  endtask

  // monitor: pops expected start requests as the design produces them
  always @(posedge clk) begin
    #2;
    if (rst_n && start_valid) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R6 R7: unexpected start ch %0d ctrl %h expected none", start_chan, start_ctrl);
      end else begin
        chk("R5 start payload", {start_chan, start_addr, start_block, start_ctrl}, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 7; i++) begin
      m_addr[i] = '0; m_blk[i] = '0; m_ctrl[i] = '0;
    end
    m_en = '0; m_stat = '0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_half = 1'b0; bus_addr = '0;
    bus_wdata = '0; xfer_done = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 start_valid", 99'(start_valid), 99'(0));
    rd(7'h20, 32'h0, "R1 addr ch2");
    rd(7'h68, 32'h0, "R1 ctrl ch6");
    rd(7'h70, 32'h0, "R1 enable");
    rd(7'h74, 32'h0, "R1 status");

    // R2 word access
    wr(7'h20, 1'b0, 32'h8001_2340);
    wr(7'h24, 1'b0, 32'h0010_0004);
    rd(7'h20, m_addr[2], "R2 addr ch2");
    rd(7'h24, m_blk[2], "R2 block ch2");

    // R3 halfword lanes
    wr(7'h22, 1'b1, 32'hDEAD_5A5A);
    rd(7'h20, 32'h5A5A_2340, "R3 addr upper half");
    wr(7'h34, 1'b1, 32'h0000_00FF);
    rd(7'h34, 32'h0000_00FF, "R3 block lower half");
    wr(7'h70, 1'b1, 32'h0000_8808);
    wr(7'h72, 1'b1, 32'h0000_0888);
    rd(7'h70, 32'h0888_8808, "R3 enable halves");

    // R5 gated start
    wr(7'h28, 1'b0, 32'h0100_0201);
    rd(7'h28, m_ctrl[2], "R5 ctrl stored");

    // R6 gate clear and start bit clear
    wr(7'h18, 1'b0, 32'h0100_0001);
    wr(7'h08, 1'b0, 32'h0000_0401);
    rd(7'h18, 32'h0100_0001, "R6 ch1 stored without start");

    // R7 channel 5 never starts
    wr(7'h58, 1'b0, 32'h0100_0000);
    rd(7'h5C, 32'h0100_0000, "R7 ch5 stored");

    // R4 halfword at +0xC acts as full word
    wr(7'h30, 1'b0, 32'h0000_3000);
    wr(7'h3C, 1'b1, 32'h0100_0003);
    rd(7'h38, 32'h0100_0003, "R4 full word via +0xC halfword");

    // R8 restart while busy
    wr(7'h28, 1'b0, 32'h0100_0202);
    rd(7'h74, 32'h0000_0004, "R8 restart flag ch2");
    wr(7'h74, 1'b0, 32'h0000_0001);
    rd(7'h74, 32'h0000_0004, "R8 flag stays on other clear");
    wr(7'h74, 1'b0, 32'h0000_0004);
    rd(7'h74, 32'h0000_0000, "R8 flag cleared");

    // R9 completion clears busy
    done_pulse(2);
    rd(7'h28, 32'h0000_0202, "R9 busy cleared");
    wr(7'h28, 1'b0, 32'h0100_0203);
    rd(7'h74, 32'h0000_0000, "R9 no restart after done");

    // R9 done and write collide: write wins, restart seen
    xfer_done[2] = 1'b1;
    wr(7'h28, 1'b0, 32'h0100_0204);
    xfer_done = '0;
    rd(7'h28, 32'h0100_0204, "R9 write wins over done");
    rd(7'h74, 32'h0000_0004, "R9 restart on stale busy");

    // R10 back-to-back starts
    wr(7'h40, 1'b0, 32'h0000_4000);
    wr(7'h60, 1'b0, 32'h0000_6000);
    wr(7'h48, 1'b0, 32'h0100_0004);
    wr(7'h68, 1'b0, 32'h0100_0006);
    repeat (3) @(negedge clk);
    chk("R10 all expected starts seen", 99'(exp_q.size()), 99'(0));

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule